// File: doc/BRIEF.md
# PLL Reprogramming and Lock-Check Sequencer

This block applies a new PLL setting and reports whether it took. A one-cycle start pulse captures the divider fields and the target output rate. The block then packs the fields into a 32-bit PLL control word and issues it over a single-cycle register-write strobe. It waits a fixed lock interval of 100 microseconds and then samples the two PLL status bits once. It ends with a one-cycle done pulse that carries a timeout flag and a configuration-error flag.

When the PLL feeds the core clock, the sequencer also owns the select of a companion interface-clock divider. The order of that write depends on the target rate. A target above 500 MHz forces divide-by-2 before the PLL is touched. A target at or below 500 MHz returns the divider to divide-by-1 only after the PLL has relocked cleanly. For other clock domains the divider is never written. The analog PLL sits outside the block, and its lock and error bits arrive on an input.

Top module: `pll_reprog_seq`

## Requirements
- R1: The control word puts odiv in bits 3:2, idiv in bits 8:4, fbdiv in bits 15:9 and band in bit 20. Bit 0 (powerdown), bit 1 (bypass) and every other bit are written as zero. The word is issued with exactly one `pll_wr_o` cycle per accepted start.
- R2: Status is sampled once, after the lock interval (100 us, i.e. `LOCK_CYC` cycles of the sequencer clock). The done pulse follows the control-word write cycle by `LOCK_CYC`+2 cycles, or by `LOCK_CYC`+3 cycles when a divide-by-1 write is inserted. A lock that appears partway through the wait still counts as success.
- R3: If the lock bit (`pll_stat_i[0]`) is clear at the sample, done carries `timeout_o`=1 and `cfg_err_o`=0.
- R4: If the lock bit is set and the error bit (`pll_stat_i[1]`) is also set, done carries `cfg_err_o`=1 and `timeout_o`=0. The two flags are never both set.
- R5: For the core domain with a target strictly above 500 MHz, the interface divider select is written with 1 (divide-by-2) in the cycle immediately before the control-word write. A target of exactly 500 MHz does not count as above.
- R6: For the core domain with a target of 500 MHz or less and a clean relock, the select is written with 0 (divide-by-1) after the status sample, in the cycle just before done.
- R7: For the core domain, if the relock fails (timeout or error), no divide-by-1 write is made. A divide-by-2 already written stays in place.
- R8: When `core_dom_i` is 0, the interface divider is never written, whatever the rate or outcome.
- R9: A start pulse that arrives while a sequence is running is ignored. It produces no extra writes and no extra done.
- R10: `done_o` is a single-cycle pulse. `timeout_o` and `cfg_err_o` are 0 whenever `done_o` is 0.
- R11: After reset, all outputs are 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures all request fields |
| core_dom_i | input | 1 | 1 when the PLL drives the core clock |
| rate_i | input | 32 | Target PLL rate in Hz |
| idiv_i | input | 5 | Input divider field |
| fbdiv_i | input | 7 | Feedback divider field |
| odiv_i | input | 2 | Output divider field |
| band_i | input | 1 | Band field |
| pll_stat_i | input | 2 | PLL status: bit 0 lock, bit 1 error |
| pll_wr_o | output | 1 | Control-word write strobe |
| pll_wdata_o | output | 32 | Control word |
| ifdiv_wr_o | output | 1 | Interface divider select write strobe |
| ifdiv_sel_o | output | 1 | Select value: 0 divide-by-1, 1 divide-by-2 |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Lock missing at sample; valid with done |
| cfg_err_o | output | 1 | Locked with error; valid with done |

## Verification
The bench targets the asymmetric ordering around the interface divider. It uses a target of exactly 500 MHz and one of 500 MHz plus 1 Hz. A comparison with the wrong sense would move the divide-by-2 write to the wrong side of the PLL write, or drop it, and the ordered scoreboard reports either as a mismatch.

Failed relocks are run on both sides of the threshold. A design that restores divide-by-1 on failure, or that writes the divider for a non-core domain, would produce an event the scoreboard does not expect.

One run raises lock only halfway through the wait and fires a second start meanwhile. An early sample would report a false timeout, and a design that accepts the second start would issue extra writes. The write-to-done distance is checked exactly, so a lock counter that is off by one is also caught.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned ODIV_LSB  = 2;
  localparam int unsigned IDIV_LSB  = 4;
  localparam int unsigned FBDIV_LSB = 9;
  localparam int unsigned BAND_LSB  = 20;

  localparam logic IFDIV_BY1 = 1'b0;
  localparam logic IFDIV_BY2 = 1'b1;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE_DIV, S_WRITE, S_WAIT, S_CHECK, S_POST_DIV, S_DONE
  } seq_state_e;
endpackage

// File: rtl/pll_ctrl_pack.sv
module pll_ctrl_pack
  import pll_seq_pkg::*;
#(
  parameter int unsigned IDIV_W  = 5,
  parameter int unsigned FBDIV_W = 7,
  parameter int unsigned ODIV_W  = 2,
  parameter int unsigned BAND_W  = 1
) (
  input  logic [IDIV_W-1:0]  idiv_i,
  input  logic [FBDIV_W-1:0] fbdiv_i,
  input  logic [ODIV_W-1:0]  odiv_i,
  input  logic [BAND_W-1:0]  band_i,
  output logic [CTRL_W-1:0]  word_o
);
  // powerdown and bypass stay zero
  always_comb begin
    word_o = '0;
    word_o[ODIV_LSB  +: ODIV_W]  = odiv_i;
    word_o[IDIV_LSB  +: IDIV_W]  = idiv_i;
    word_o[FBDIV_LSB +: FBDIV_W] = fbdiv_i;
    word_o[BAND_LSB  +: BAND_W]  = band_i;
  end
endmodule

// File: rtl/lock_wait_timer.sv
module lock_wait_timer #(
  parameter int unsigned CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= LOAD_V;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned LOCK_US   = 100,
  parameter int unsigned RATE_W    = 32,
  parameter int unsigned THRESH_HZ = 500_000_000,
  parameter int unsigned IDIV_W    = 5,
  parameter int unsigned FBDIV_W   = 7,
  parameter int unsigned ODIV_W    = 2,
  parameter int unsigned BAND_W    = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               core_dom_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [IDIV_W-1:0]  idiv_i,
  input  logic [FBDIV_W-1:0] fbdiv_i,
  input  logic [ODIV_W-1:0]  odiv_i,
  input  logic [BAND_W-1:0]  band_i,
  input  logic [1:0]         pll_stat_i,
  output logic               pll_wr_o,
  output logic [31:0]        pll_wdata_o,
  output logic               ifdiv_wr_o,
  output logic               ifdiv_sel_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               cfg_err_o
);
  localparam int unsigned LOCK_CYC = (CLK_HZ / 1_000_000) * LOCK_US;
  localparam logic [RATE_W-1:0] THRESH_V = RATE_W'(THRESH_HZ);

  seq_state_e state_q, state_d;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FBDIV_W-1:0] fbdiv_q;
  logic [ODIV_W-1:0]  odiv_q;
  logic [BAND_W-1:0]  band_q;
  logic core_q, hi_q, timeout_q, cfg_err_q;
  logic wait_over, lock_ok;

  assign lock_ok = pll_stat_i[0] & ~pll_stat_i[1];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_i)
                    state_d = (core_dom_i && (rate_i > THRESH_V)) ? S_PRE_DIV : S_WRITE;
      S_PRE_DIV:  state_d = S_WRITE;
      S_WRITE:    state_d = S_WAIT;
      S_WAIT:     if (wait_over) state_d = S_CHECK;
      S_CHECK:    state_d = (lock_ok && core_q && !hi_q) ? S_POST_DIV : S_DONE;
      S_POST_DIV: state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idiv_q    <= '0;
      fbdiv_q   <= '0;
      odiv_q    <= '0;
      band_q    <= '0;
      core_q    <= 1'b0;
      hi_q      <= 1'b0;
      timeout_q <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        idiv_q  <= idiv_i;
        fbdiv_q <= fbdiv_i;
        odiv_q  <= odiv_i;
        band_q  <= band_i;
        core_q  <= core_dom_i;
        hi_q    <= rate_i > THRESH_V;
      end
      if (state_q == S_CHECK) begin
        timeout_q <= ~pll_stat_i[0];
        cfg_err_q <= pll_stat_i[0] & pll_stat_i[1];
      end
    end
  end

  pll_ctrl_pack #(
    .IDIV_W(IDIV_W), .FBDIV_W(FBDIV_W), .ODIV_W(ODIV_W), .BAND_W(BAND_W)
  ) u_pack (
    .idiv_i (idiv_q),
    .fbdiv_i(fbdiv_q),
    .odiv_i (odiv_q),
    .band_i (band_q),
    .word_o (pll_wdata_o)
  );

  lock_wait_timer #(.CYC(LOCK_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (state_q == S_WRITE),
    .expired_o(wait_over)
  );

  assign pll_wr_o    = (state_q == S_WRITE);
  assign ifdiv_wr_o  = (state_q == S_PRE_DIV) || (state_q == S_POST_DIV);
  assign ifdiv_sel_o = (state_q == S_PRE_DIV) ? IFDIV_BY2 : IFDIV_BY1;
  assign done_o      = (state_q == S_DONE);
  assign timeout_o   = done_o & timeout_q;
  assign cfg_err_o   = done_o & cfg_err_q;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pll_wr_o,
  input logic ifdiv_wr_o,
  input logic ifdiv_sel_o,
  input logic done_o,
  input logic timeout_o,
  input logic cfg_err_o
);
  a_r10_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_flags_need_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(timeout_o || cfg_err_o));

  a_r4_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(timeout_o && cfg_err_o));

  a_r5_div2_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifdiv_wr_o && ifdiv_sel_o) |=> pll_wr_o);

  a_r6_div1_then_clean_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifdiv_wr_o && !ifdiv_sel_o) |=> (done_o && !timeout_o && !cfg_err_o));

  a_r2_quiet_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_wr_o |=> (!pll_wr_o && !ifdiv_wr_o && !done_o));

  a_r9_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pll_wr_o && ifdiv_wr_o));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (.*);

// File: tb/tb_pll_reprog_seq.sv
`timescale 1ns/1ps
module tb_pll_reprog_seq;
  localparam int LOCK_CYC = 10000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        core_dom_i = 1'b0;
  logic [31:0] rate_i = '0;
  logic [4:0]  idiv_i = '0;
  logic [6:0]  fbdiv_i = '0;
  logic [1:0]  odiv_i = '0;
  logic [0:0]  band_i = '0;
  logic [1:0]  pll_stat_i = '0;
  logic        pll_wr_o, ifdiv_wr_o, ifdiv_sel_o, done_o, timeout_o, cfg_err_o;
  logic [31:0] pll_wdata_o;

  always #5 clk_i = ~clk_i;

  pll_reprog_seq dut (.*);

  typedef struct {int kind; logic [31:0] data; int dly; int req;} exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, wr_cyc = 0, n_done = 0;
  bit after_done = 0, finished = 0;

  // kind 0: divider select write, 1: control word write, 2: done {timeout,cfg_err}
  task automatic check_evt(input int kind, input logic [31:0] data, input int dly);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R9: unexpected event kind %0d data %h, expected none", kind, data);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.data !== data || (kind == 2 && e.dly != dly)) begin
        n_fail++;
        $display("FAIL R%0d: got kind %0d data %h dly %0d, expected kind %0d data %h dly %0d",
                 e.req, kind, data, dly, e.kind, e.data, e.dly);
      end
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (rst_ni) begin
        if (after_done) begin
          n_chk++;  // R10
          if (done_o || timeout_o || cfg_err_o) begin
            n_fail++;
            $display("FAIL R10: done/flags %b%b%b after pulse, expected 000",
                     done_o, timeout_o, cfg_err_o);
          end
          after_done = 0;
        end
        if (ifdiv_wr_o) check_evt(0, {31'd0, ifdiv_sel_o}, 0);
        if (pll_wr_o) begin
          wr_cyc = cyc;
          check_evt(1, pll_wdata_o, 0);
        end
        if (done_o) begin
          check_evt(2, {30'd0, timeout_o, cfg_err_o}, cyc - wr_cyc);
          after_done = 1;
          n_done++;
        end
      end
    end
  end

  task automatic run_op(input bit core, input logic [31:0] rate, input logic [4:0] idv,
                        input logic [6:0] fbd, input logic [1:0] odv, input logic band,
                        input logic [1:0] stat, input bit late, input int req);
    bit hi, ok, post;
    logic [31:0] w;
    int n;
    hi   = core && (rate > 32'd500_000_000);
    ok   = stat[0] && !stat[1];
    post = core && !hi && ok;
    w = (32'(band) << 20) | (32'(fbd) << 9) | (32'(idv) << 4) | (32'(odv) << 2);
    if (hi) exp_q.push_back('{0, 32'd1, 0, req});
    exp_q.push_back('{1, w, 0, req});
    if (post) exp_q.push_back('{0, 32'd0, 0, req});
    exp_q.push_back('{2, {30'd0, !stat[0], stat[0] && stat[1]},
                      LOCK_CYC + 2 + (post ? 1 : 0), req});
    n = n_done;
    @(negedge clk_i);
    core_dom_i = core; rate_i = rate; idiv_i = idv; fbdiv_i = fbd;
    odiv_i = odv; band_i = band; pll_stat_i = late ? 2'b00 : stat;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (late) begin
      // R9: second start mid-wait must be ignored; R2: lock rises late
      repeat (4000) @(negedge clk_i);
      core_dom_i = 1'b1; rate_i = 32'd900_000_000; idiv_i = 5'd3; fbdiv_i = 7'd5;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (2000) @(negedge clk_i);
      pll_stat_i = stat;
    end
    while (n_done == n) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++;  // R11 reset state
    if (pll_wr_o || ifdiv_wr_o || done_o || timeout_o || cfg_err_o || pll_wdata_o !== 32'd0) begin
      n_fail++;
      $display("FAIL R11: outputs %b%b%b%b%b word %h, expected all zero",
               pll_wr_o, ifdiv_wr_o, done_o, timeout_o, cfg_err_o, pll_wdata_o);
    end
    // R1 R8: non-core, clean lock, all fields nonzero
    run_op(1'b0, 32'd600_000_000, 5'd17, 7'd85, 2'd3, 1'b1, 2'b01, 1'b0, 1);
    // R5: core above threshold, divide-by-2 before write
    run_op(1'b1, 32'd800_000_000, 5'd0, 7'd23, 2'd1, 1'b0, 2'b01, 1'b0, 5);
    // R6: core below threshold, divide-by-1 after relock
    run_op(1'b1, 32'd400_000_000, 5'd1, 7'd47, 2'd2, 1'b0, 2'b01, 1'b0, 6);
    // R6: exactly at threshold is not above
    run_op(1'b1, 32'd500_000_000, 5'd0, 7'd14, 2'd1, 1'b0, 2'b01, 1'b0, 6);
    // R3 R5 R7: just above threshold, no lock, divide-by-2 left in place
    run_op(1'b1, 32'd500_000_001, 5'd1, 7'd44, 2'd1, 1'b0, 2'b00, 1'b0, 3);
    // R4 R7: core below threshold, locked with error
    run_op(1'b1, 32'd300_000_000, 5'd1, 7'd35, 2'd2, 1'b1, 2'b11, 1'b0, 4);
    // R3 R7: core below threshold, no lock
    run_op(1'b1, 32'd300_000_000, 5'd1, 7'd35, 2'd2, 1'b0, 2'b00, 1'b0, 3);
    // R2 R9: lock appears mid-wait, stray start during wait
    run_op(1'b1, 32'd200_000_000, 5'd1, 7'd47, 2'd3, 1'b0, 2'b01, 1'b1, 2);
    // R8: non-core above threshold with error, no divider writes
    run_op(1'b0, 32'd1_000_000_000, 5'd31, 7'd127, 2'd0, 1'b1, 2'b10, 1'b0, 8);
    n_chk++;  // R9: nothing left pending
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9: %0d expected events missing, expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule